// File: doc/BRIEF.md
# Operand Address Generator

This block forms operand addresses for a 16-bit CPU with eight general registers and a 3-bit addressing mode. The work is split over two cycles. In the issue cycle it reads the selected register, with bypass from writes landing in that same cycle. It also checks whether the mode needs arithmetic. In the next cycle it forms the operand address from the captured mode and register value. For the stepping modes it writes the stepped register back.

A speculative address goes out in the issue cycle itself. It assumes that the register value is the address. In the same cycle the block flags that guess as cancelled when the mode needs a decrement or an index addition. The corrected address then follows one cycle later on the formed-address outputs. A general write port lets the execute stage load registers.

Top module: `opaddr_gen`

## Requirements
- R1: After reset, all eight registers read as zero, and both `spec_valid` and `ea_valid` are low.
- R2: Mode encodings are 0 register, 1 register deferred, 2 post-increment, 3 post-increment deferred, 4 pre-decrement, 5 pre-decrement deferred, 6 indexed and 7 indexed deferred. An issue in any mode other than 0 raises `spec_valid` in the same cycle, with `spec_addr` equal to the register's current value. Mode 0 raises no speculative address.
- R3: `spec_cancel` is high in the issue cycle exactly when the mode is 4 to 7. It is low for modes 1 to 3.
- R4: `ea_valid` rises in the cycle after each issue and only then. For modes 1 to 3 the formed `ea_addr` equals the speculative address of that issue.
- R5: Mode 0 raises `ea_reg_op` and drives `ea_addr` to zero.
- R6: Modes 2 and 3 give the original register value as the address and write back the register plus the step.
- R7: Modes 4 and 5 give the register minus the step as the address and write that value back.
- R8: The step is 1 when `issue_byte` is high and 2 when it is low. For registers 6 and 7 the step is always 2.
- R9: Modes 6 and 7 give the register plus `issue_index` modulo 2^16, with the index sampled in the issue cycle. These modes leave the register unchanged.
- R10: `ea_deferred` is high for modes 1, 3, 5 and 7, and low otherwise.
- R11: A read in the issue cycle sees writes that land in the same cycle. When a step writeback and a general write hit the same register in one cycle, the step writeback wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An operand specifier is presented this cycle |
| issue_mode | input | 3 | Addressing mode |
| issue_reg | input | 3 | Register number |
| issue_byte | input | 1 | Byte-sized operand |
| issue_index | input | 16 | Index word for modes 6 and 7 |
| gw_en | input | 1 | General register write enable |
| gw_sel | input | 3 | General write register number |
| gw_data | input | 16 | General write data |
| spec_valid | output | 1 | Speculative address issued |
| spec_cancel | output | 1 | Speculative address is wrong for this mode |
| spec_addr | output | 16 | Speculative address (the register value) |
| ea_valid | output | 1 | Formed result valid |
| ea_addr | output | 16 | Formed operand address |
| ea_reg_op | output | 1 | Operand is the register itself |
| ea_deferred | output | 1 | Address points to a pointer |

## Verification
The assertions assume an issue can come in every cycle. They also assume that the general write port may target any register at any time, even the register that an in-flight step is writing back. The stimulus therefore mixes back-to-back issues on the same register, general writes that collide with step writebacks, and idle cycles. All of these stay inside the legal encodings of the 3-bit fields. Index words and register values cover the wraparound at zero and at 16'hFFFF, so the modular arithmetic is exercised without any precondition on operand values.

// File: rtl/oag_pkg.sv
package oag_pkg;

  typedef enum logic [2:0] {
    AM_REG     = 3'd0,
    AM_REG_DEF = 3'd1,
    AM_INC     = 3'd2,
    AM_INC_DEF = 3'd3,
    AM_DEC     = 3'd4,
    AM_DEC_DEF = 3'd5,
    AM_IDX     = 3'd6,
    AM_IDX_DEF = 3'd7
  } amode_e;

  // Modes 4..7 need arithmetic before the address is known.
  function automatic logic needs_second(input logic [2:0] m);
    return m[2];
  endfunction

  // Odd modes deliver a pointer.
  function automatic logic is_deferred(input logic [2:0] m);
    return m[0];
  endfunction

  // Step size: byte ops step by one, except on the stack and program registers.
  function automatic logic [1:0] step_amt(input logic byte_op, input logic wide_reg);
    return (byte_op && !wide_reg) ? 2'd1 : 2'd2;
  endfunction

endpackage

// File: rtl/oag_regfile.sv
module oag_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          wb_en,
  input  logic [RW-1:0] wb_sel,
  input  logic [DW-1:0] wb_data,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_sel,
  input  logic [DW-1:0] wr_data
);

  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit_wb, hit_wr;
    assign hit_wb = wb_en && (wb_sel == RW'(g));
    assign hit_wr = wr_en && (wr_sel == RW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      regs[g] <= '0;
      else if (hit_wb) regs[g] <= wb_data;
      else if (hit_wr) regs[g] <= wr_data;
    end
  end

  // Same-cycle bypass, step writeback first.
  logic byp_wb, byp_wr;
  assign byp_wb = wb_en && (wb_sel == rd_sel);
  assign byp_wr = wr_en && (wr_sel == rd_sel);

  always_comb begin
    if (byp_wb)      rd_data = wb_data;
    else if (byp_wr) rd_data = wr_data;
    else             rd_data = regs[rd_sel];
  end

  // R11: a colliding step writeback must be the value stored.
  assert_wb_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && wr_en && wb_sel == wr_sel && rd_sel == wb_sel) |-> (rd_data == wb_data));

endmodule

// File: rtl/oag_decode.sv
module oag_decode #(
  parameter int DW = 16
) (
  input  logic          in_valid,
  input  logic [2:0]    in_mode,
  input  logic [DW-1:0] rd_data,
  output logic          spec_valid,
  output logic          spec_cancel,
  output logic [DW-1:0] spec_addr
);
  import oag_pkg::*;

  logic mem_mode;
  assign mem_mode    = (amode_e'(in_mode) != AM_REG);
  assign spec_valid  = in_valid && mem_mode;
  assign spec_cancel = in_valid && needs_second(in_mode);
  assign spec_addr   = rd_data;

endmodule

// File: rtl/oag_form.sv
module oag_form #(
  parameter int DW     = 16,
  parameter int RW     = 3,
  parameter int SP_SEL = 6,
  parameter int PC_SEL = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    in_mode,
  input  logic [RW-1:0] in_sel,
  input  logic          in_byte,
  input  logic [DW-1:0] in_index,
  input  logic [DW-1:0] in_val,
  output logic          out_valid,
  output logic [DW-1:0] out_addr,
  output logic          out_reg_op,
  output logic          out_deferred,
  output logic          wb_en,
  output logic [RW-1:0] wb_sel,
  output logic [DW-1:0] wb_data
);
  import oag_pkg::*;

  logic          s_valid;
  logic [2:0]    s_mode;
  logic [RW-1:0] s_sel;
  logic          s_byte;
  logic [DW-1:0] s_idx;
  logic [DW-1:0] s_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      s_mode  <= '0;
      s_sel   <= '0;
      s_byte  <= 1'b0;
      s_idx   <= '0;
      s_val   <= '0;
    end else begin
      s_valid <= in_valid;
      if (in_valid) begin
        s_mode <= in_mode;
        s_sel  <= in_sel;
        s_byte <= in_byte;
        s_idx  <= in_index;
        s_val  <= in_val;
      end
    end
  end

  logic          wide_reg;
  logic [DW-1:0] stepv, val_up, val_dn, val_ix;

  assign wide_reg = (s_sel == RW'(SP_SEL)) || (s_sel == RW'(PC_SEL));
  assign stepv    = {{(DW-2){1'b0}}, step_amt(s_byte, wide_reg)};
  assign val_up   = s_val + stepv;
  assign val_dn   = s_val - stepv;
  assign val_ix   = s_val + s_idx;

  always_comb begin
    out_addr = '0;
    wb_en    = 1'b0;
    wb_data  = s_val;
    unique case (amode_e'(s_mode))
      AM_REG:             out_addr = '0;
      AM_REG_DEF:         out_addr = s_val;
      AM_INC, AM_INC_DEF: begin out_addr = s_val;  wb_en = s_valid; wb_data = val_up; end
      AM_DEC, AM_DEC_DEF: begin out_addr = val_dn; wb_en = s_valid; wb_data = val_dn; end
      AM_IDX, AM_IDX_DEF: out_addr = val_ix;
      default:            out_addr = '0;
    endcase
  end

  assign wb_sel       = s_sel;
  assign out_valid    = s_valid;
  assign out_reg_op   = s_valid && (amode_e'(s_mode) == AM_REG);
  assign out_deferred = s_valid && is_deferred(s_mode);

  // R7: pre-decrement writes back the address it formed.
  assert_dec_wb_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && s_mode[2]) |-> (wb_data == out_addr));
  // R6, R8: post-increment writes back address plus one or two.
  assert_inc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !s_mode[2]) |->
      ((DW'(wb_data - out_addr) == DW'(1)) || (DW'(wb_data - out_addr) == DW'(2))));
  // R5: a register operand is neither deferred nor addressed.
  assert_regop_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_reg_op |-> (!out_deferred && out_addr == '0 && !wb_en));
  // R10: the deferred flag only accompanies a formed result.
  assert_deferred_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_deferred |-> out_valid);
  // R9: indexed modes never write back.
  assert_index_no_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && s_mode[2] && s_mode[1]) |-> !wb_en);

endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen #(
  parameter int DW     = 16,
  parameter int NREG   = 8,
  parameter int SP_SEL = 6,
  parameter int PC_SEL = 7,
  localparam int RW    = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  input  logic [2:0]    issue_mode,
  input  logic [RW-1:0] issue_reg,
  input  logic          issue_byte,
  input  logic [DW-1:0] issue_index,
  input  logic          gw_en,
  input  logic [RW-1:0] gw_sel,
  input  logic [DW-1:0] gw_data,
  output logic          spec_valid,
  output logic          spec_cancel,
  output logic [DW-1:0] spec_addr,
  output logic          ea_valid,
  output logic [DW-1:0] ea_addr,
  output logic          ea_reg_op,
  output logic          ea_deferred
);

  logic [DW-1:0] rd_data;
  logic          wb_en;
  logic [RW-1:0] wb_sel;
  logic [DW-1:0] wb_data;

  oag_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_sel(issue_reg), .rd_data(rd_data),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data),
    .wr_en(gw_en), .wr_sel(gw_sel), .wr_data(gw_data)
  );

  oag_decode #(.DW(DW)) u_dec (
    .in_valid(issue_valid), .in_mode(issue_mode), .rd_data(rd_data),
    .spec_valid(spec_valid), .spec_cancel(spec_cancel), .spec_addr(spec_addr)
  );

  oag_form #(.DW(DW), .RW(RW), .SP_SEL(SP_SEL), .PC_SEL(PC_SEL)) u_form (
    .clk(clk), .rst_n(rst_n),
    .in_valid(issue_valid), .in_mode(issue_mode), .in_sel(issue_reg),
    .in_byte(issue_byte), .in_index(issue_index), .in_val(rd_data),
    .out_valid(ea_valid), .out_addr(ea_addr), .out_reg_op(ea_reg_op),
    .out_deferred(ea_deferred),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data)
  );

  // R3: a cancel never arrives without a speculative address.
  assert_cancel_has_spec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spec_cancel |-> spec_valid);
  // R4: an uncancelled guess is confirmed one cycle later.
  assert_spec_confirmed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_valid && !spec_cancel) |=> (ea_valid && ea_addr == $past(spec_addr)));
  // R4: every issue yields exactly one formed result next cycle.
  assert_issue_to_ea_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> ea_valid);
  assert_no_issue_no_ea_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> !ea_valid);

endmodule

// File: tb/opaddr_gen_test.sv
module opaddr_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [2:0]  issue_mode = '0;
  logic [2:0]  issue_reg = '0;
  logic        issue_byte = 1'b0;
  logic [15:0] issue_index = '0;
  logic        gw_en = 1'b0;
  logic [2:0]  gw_sel = '0;
  logic [15:0] gw_data = '0;
  logic        spec_valid, spec_cancel, ea_valid, ea_reg_op, ea_deferred;
  logic [15:0] spec_addr, ea_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  opaddr_gen uut (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_mode(issue_mode), .issue_reg(issue_reg),
    .issue_byte(issue_byte), .issue_index(issue_index),
    .gw_en(gw_en), .gw_sel(gw_sel), .gw_data(gw_data),
    .spec_valid(spec_valid), .spec_cancel(spec_cancel), .spec_addr(spec_addr),
    .ea_valid(ea_valid), .ea_addr(ea_addr), .ea_reg_op(ea_reg_op),
    .ea_deferred(ea_deferred)
  );

  int checks = 0;
  int fails  = 0;

  // Behavioural reference state.
  int regs [8];
  bit p_v = 0;
  int p_mode, p_addr, p_wbv, p_sel;
  bit p_wb;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int step_of(int sel, bit byt);
    if (sel >= 6) return 2;
    return byt ? 1 : 2;
  endfunction

  // One clock: drive, check against the model, then advance the model.
  task automatic cyc(bit v, int m, int s, bit byt, int ix,
                     bit we, int ws, int wd, string tag = "");
    int nr [8];
    int rv, st;
    @(negedge clk);
    issue_valid = v; issue_mode = 3'(m); issue_reg = 3'(s);
    issue_byte = byt; issue_index = 16'(ix);
    gw_en = we; gw_sel = 3'(ws); gw_data = 16'(wd);
    #2;
    nr = regs;
    if (we) nr[ws] = wd & 16'hFFFF;
    if (p_v && p_wb) nr[p_sel] = p_wbv;   // R11: step writeback wins
    rv = nr[s];
    chk("R2 spec_valid", int'(spec_valid), int'(v && m != 0));
    chk("R3 spec_cancel", int'(spec_cancel), int'(v && m >= 4));
    if (v && m != 0) chk(tag != "" ? tag : "R2 spec_addr", int'(spec_addr), rv);
    chk("R4 ea_valid", int'(ea_valid), int'(p_v));
    if (p_v) begin
      string rq;
      case (p_mode)
        0: rq = "R5 ea_addr";
        1: rq = "R4 ea_addr";
        2, 3: rq = "R6 ea_addr";
        4, 5: rq = "R7 ea_addr";
        default: rq = "R9 ea_addr";
      endcase
      chk(rq, int'(ea_addr), p_addr);
      chk("R5 ea_reg_op", int'(ea_reg_op), int'(p_mode == 0));
      chk("R10 ea_deferred", int'(ea_deferred), p_mode % 2);
    end
    regs = nr;
    p_v = v;
    if (v) begin
      st = step_of(s, byt);
      p_mode = m; p_sel = s; p_wb = 0;
      case (m)
        0: p_addr = 0;
        1: p_addr = rv;
        2, 3: begin p_addr = rv; p_wb = 1; p_wbv = (rv + st) & 16'hFFFF; end
        4, 5: begin p_addr = (rv - st) & 16'hFFFF; p_wb = 1; p_wbv = p_addr; end
        default: p_addr = (rv + ix) & 16'hFFFF;
      endcase
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 spec_valid in reset", int'(spec_valid), 0);
    chk("R1 ea_valid in reset", int'(ea_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    // R1: untouched registers read zero.
    cyc(1, 1, 3, 0, 0, 0, 0, 0, "R1 reset value");
    cyc(1, 1, 7, 0, 0, 0, 0, 0, "R1 reset value");
    // Load registers through the general port.
    for (int r = 0; r < 8; r++) cyc(0, 0, 0, 0, 0, 1, r, 16'h1000 + r * 16'h0100);
    cyc(0, 0, 0, 0, 0, 1, 2, 16'h0000);
    cyc(0, 0, 0, 0, 0, 1, 4, 16'hFFFF);
    // Every mode once, word sized.
    for (int m = 0; m < 8; m++) cyc(1, m, 1, 0, 16'h0040, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    // R8: byte steps by one on R3, by two on R6 and R7.
    cyc(1, 2, 3, 1, 0, 0, 0, 0);
    cyc(1, 1, 3, 0, 0, 0, 0, 0, "R8 byte inc by 1");
    cyc(1, 2, 6, 1, 0, 0, 0, 0);
    cyc(1, 1, 6, 0, 0, 0, 0, 0, "R8 sp byte inc by 2");
    cyc(1, 4, 7, 1, 0, 0, 0, 0);
    cyc(1, 1, 7, 0, 0, 0, 0, 0, "R8 pc byte dec by 2");
    cyc(1, 5, 3, 1, 0, 0, 0, 0);
    cyc(1, 1, 3, 0, 0, 0, 0, 0, "R8 byte dec by 1");
    // Wraparound: decrement through zero, increment through FFFF, index wrap.
    cyc(1, 4, 2, 0, 0, 0, 0, 0);
    cyc(1, 1, 2, 0, 0, 0, 0, 0, "R7 decrement wraps");
    cyc(1, 2, 4, 1, 0, 0, 0, 0);
    cyc(1, 1, 4, 0, 0, 0, 0, 0, "R6 increment wraps");
    cyc(1, 6, 5, 0, 16'hF000, 0, 0, 0);
    cyc(1, 7, 5, 0, 16'hFFFF, 0, 0, 0);
    cyc(1, 1, 5, 0, 0, 0, 0, 0, "R9 index leaves register");
    // R11: back-to-back on the same register, and a colliding general write.
    cyc(1, 3, 1, 0, 0, 0, 0, 0);
    cyc(1, 3, 1, 0, 0, 0, 0, 0, "R11 bypass of step");
    cyc(1, 1, 1, 0, 0, 1, 1, 16'h5555, "R11 step beats general write");
    cyc(1, 1, 0, 0, 0, 1, 0, 16'h0ABC, "R11 general write bypass");
    // Mixed traffic.
    for (int k = 0; k < 600; k++)
      cyc(bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, 7)),
          int'($urandom_range(0, 7)), bit'($urandom_range(0, 1)),
          int'($urandom_range(0, 16'hFFFF)), bit'($urandom_range(0, 3) == 0),
          int'($urandom_range(0, 7)), int'($urandom_range(0, 16'hFFFF)));
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule